// File: doc/BRIEF.md
# Serial Channel Clock Selector and Baud Generator

This block makes the bit-rate timing for one channel of a two-channel serial controller. Four clock sources are available to it: two external clock pins (here called the A-pin and the B-pin), a recovered-clock input, and an internal baud counter. The counter runs from the system clock or from A-pin rising edges, and it toggles a square-wave output each time it counts down through zero. The transmitter and the receiver each have their own source select. Each direction divides the rising edges of its source by 1, 16, 32 or 64 and gives one single-cycle bit tick per bit period. The B-pin can also serve as a clock output and carry one of four internal clocks.

The block runs on the system clock. The pin and recovered-clock inputs are levels that are already synchronous to it, and the block finds their rising edges. All settings come in as register values from a register file outside the block. The B-pin source supports only the direct 1/16/32/64 prescale. The system clock reaches the transmitter or receiver only through the baud counter, so its effective divisor is always even and at least 4. The A-pin can be used directly or through the counter.

Top module: `sccClockGen`

## Requirements
- R1: After reset, txBitTick, rxBitTick, brgClk, brgZero and brgIrq are all 0.
- R2: The transmit source is clkCtrlReg[4:3]: 00 A-pin, 01 B-pin, 10 baud counter output, 11 recovered clock. txBitTick counts rising edges of the selected source only.
- R3: The receive source is clkCtrlReg[6:5], with the same codes as R2, and it is independent of the transmit select.
- R4: modeReg[7:6] sets the prescale for both directions: 00 gives one bit tick per source rising edge, 01 one per 16, 10 one per 32 and 11 one per 64.
- R5: pllCtrlReg[0] enables the baud counter. While it is 0, brgClk stays 0 and brgZero is never set.
- R6: pllCtrlReg[1]=1 clocks the counter on every system clock. pllCtrlReg[1]=0 clocks it on A-pin rising edges only.
- R7: With time constant TC = {tcHigh,tcLow}, brgClk toggles once every TC+2 counter clocks, so its full period is 2*(TC+2) counter clocks.
- R8: A change to tcLow or tcHigh does not alter the half period in progress. It applies from the next reload on.
- R9: Each time the counter reaches zero, brgZero is set. It stays set until a zeroClr pulse, and a reach of zero in the same cycle wins over the clear. brgIrq is brgZero gated by intCtrlReg[1].
- R10: trxcOe equals clkCtrlReg[2]. trxcOut is chosen by clkCtrlReg[1:0]: 00 A-pin level (crystal), 01 transmit source level, 10 brgClk, 11 recovered clock level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the counter's internal clock source |
| rstN | input | 1 | Asynchronous reset, active low |
| clkCtrlReg | input | 8 | Clock routing: pin output select, pin direction, transmit and receive source |
| pllCtrlReg | input | 8 | Bit 0 counter enable, bit 1 counter clock select |
| modeReg | input | 8 | Bits 7:6 clock-mode prescale |
| intCtrlReg | input | 8 | Bit 1 zero-count interrupt enable |
| tcLow | input | 8 | Time constant, low byte |
| tcHigh | input | 8 | Time constant, high byte |
| zeroClr | input | 1 | One-cycle pulse that clears brgZero |
| rtxcIn | input | 1 | A-pin clock level |
| trxcIn | input | 1 | B-pin clock level |
| recovClkIn | input | 1 | Recovered clock level |
| txBitTick | output | 1 | One-cycle transmit bit tick |
| rxBitTick | output | 1 | One-cycle receive bit tick |
| brgClk | output | 1 | Baud counter square-wave output |
| brgZero | output | 1 | Sticky zero-count status |
| brgIrq | output | 1 | Zero-count interrupt request |
| trxcOut | output | 1 | Clock driven onto the B-pin |
| trxcOe | output | 1 | B-pin output enable |

## Verification
The assertions assume that a pin or recovered-clock input, once high, stays high for at least one full cycle before it falls, so no two rising edges of one source come in consecutive cycles. The stimulus keeps to this: every pin pulse is one cycle high and one cycle low. The assertions also assume that register values change only while the affected path is idle or in reset. The bench therefore reprograms the routing and the mode only after a fresh reset, and it changes only the time constant while the counter runs.

// File: rtl/sccClkPkg.sv
package sccClkPkg;

  localparam int PRESC_W = 6;

  typedef enum logic [1:0] {
    SRC_APIN  = 2'b00,
    SRC_BPIN  = 2'b01,
    SRC_BAUD  = 2'b10,
    SRC_RECOV = 2'b11
  } clkSrcE;

  typedef enum logic [1:0] {
    MODE_X1  = 2'b00,
    MODE_X16 = 2'b01,
    MODE_X32 = 2'b10,
    MODE_X64 = 2'b11
  } clkModeE;

  typedef enum logic {
    BRG_COUNT  = 1'b0,
    BRG_RELOAD = 1'b1
  } brgStateE;

  // strobes from control to the baud datapath
  typedef struct packed {
    logic hold;   // counter disabled: preload, output low
    logic load;   // reload tick after reaching zero
    logic dec;    // ordinary count-down tick
    logic flip;   // zero reached: toggle output, flag status
  } brgStrobeS;

  function automatic logic [PRESC_W-1:0] modeLimit(clkModeE m);
    case (m)
      MODE_X1:  modeLimit = PRESC_W'(0);
      MODE_X16: modeLimit = PRESC_W'(15);
      MODE_X32: modeLimit = PRESC_W'(31);
      default:  modeLimit = PRESC_W'(63);
    endcase
  endfunction

endpackage

// File: rtl/sccPrescale.sv
module sccPrescale
  import sccClkPkg::*;
#(
  parameter int CNT_W = PRESC_W
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    srcEdge,
  input  clkModeE mode,
  output logic    bitTick
);

  logic [CNT_W-1:0] edgeCnt;
  logic [CNT_W-1:0] limit;
  logic             atLimit;

  assign limit   = CNT_W'(modeLimit(mode));
  assign atLimit = (edgeCnt >= limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
      bitTick <= 1'b0;
    end else begin
      bitTick <= srcEdge & atLimit;
      if (srcEdge) begin
        if (atLimit) edgeCnt <= '0;
        else         edgeCnt <= edgeCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sccClkCtrl.sv
module sccClkCtrl
  import sccClkPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      brgEnable,
  input  logic      brgUseSys,
  input  logic      rtxcIn,
  input  logic      trxcIn,
  input  logic      recovClkIn,
  input  logic      cntZero,
  output logic      rtxcRise,
  output logic      trxcRise,
  output logic      recovRise,
  output brgStrobeS strb
);

  logic     rtxcPrev, trxcPrev, recovPrev;
  brgStateE state;
  logic     brgTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rtxcPrev  <= 1'b0;
      trxcPrev  <= 1'b0;
      recovPrev <= 1'b0;
    end else begin
      rtxcPrev  <= rtxcIn;
      trxcPrev  <= trxcIn;
      recovPrev <= recovClkIn;
    end
  end

  assign rtxcRise  = rtxcIn & ~rtxcPrev;
  assign trxcRise  = trxcIn & ~trxcPrev;
  assign recovRise = recovClkIn & ~recovPrev;

  assign brgTick = brgEnable & (brgUseSys | rtxcRise);

  always_comb begin
    strb      = '0;
    strb.hold = ~brgEnable;
    if (brgTick) begin
      if (state == BRG_RELOAD) strb.load = 1'b1;
      else if (cntZero)        strb.flip = 1'b1;
      else                     strb.dec  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          state <= BRG_COUNT;
    else if (strb.hold) state <= BRG_COUNT;
    else if (strb.flip) state <= BRG_RELOAD;
    else if (strb.load) state <= BRG_COUNT;
  end

endmodule

// File: rtl/sccClkDatapath.sv
module sccClkDatapath
  import sccClkPkg::*;
#(
  parameter int TC_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  brgStrobeS       strb,
  input  logic [TC_W-1:0] tcValue,
  input  clkSrcE          txSel,
  input  clkSrcE          rxSel,
  input  logic [1:0]      pinSel,
  input  clkModeE         mode,
  input  logic            rtxcRise,
  input  logic            trxcRise,
  input  logic            recovRise,
  input  logic            rtxcIn,
  input  logic            trxcIn,
  input  logic            recovClkIn,
  input  logic            zeroClr,
  input  logic            zeroIntEn,
  output logic            cntZero,
  output logic            brgClk,
  output logic            brgZero,
  output logic            brgIrq,
  output logic            trxcOut,
  output logic            txBitTick,
  output logic            rxBitTick
);

  localparam int NUM_DIR = 2;
  localparam int NUM_SRC = 4;

  logic [TC_W-1:0]    cnt;
  logic               brgRise;
  logic [NUM_SRC-1:0] srcRise;
  logic [NUM_SRC-1:0] srcLevel;
  clkSrcE             dirSel  [NUM_DIR];
  logic               dirEdge [NUM_DIR];
  logic               dirTick [NUM_DIR];

  // baud counter
  assign cntZero = (cnt == '0);
  assign brgRise = strb.flip & ~brgClk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      brgClk <= 1'b0;
    end else if (strb.hold) begin
      cnt    <= tcValue;
      brgClk <= 1'b0;
    end else if (strb.load) begin
      cnt    <= tcValue;
    end else if (strb.flip) begin
      brgClk <= ~brgClk;
    end else if (strb.dec) begin
      cnt    <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          brgZero <= 1'b0;
    else if (strb.flip) brgZero <= 1'b1;
    else if (zeroClr)   brgZero <= 1'b0;
  end

  assign brgIrq = brgZero & zeroIntEn;

  // source fan-in, indexed by the 2-bit select code
  assign srcRise  = {recovRise, brgRise, trxcRise, rtxcRise};
  assign srcLevel = {recovClkIn, brgClk, trxcIn, rtxcIn};

  assign dirSel[0] = txSel;
  assign dirSel[1] = rxSel;

  generate
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      assign dirEdge[d] = srcRise[dirSel[d]];
      sccPrescale #(.CNT_W(PRESC_W)) u_presc (
        .clk     (clk),
        .rstN    (rstN),
        .srcEdge (dirEdge[d]),
        .mode    (mode),
        .bitTick (dirTick[d])
      );
    end
  endgenerate

  assign txBitTick = dirTick[0];
  assign rxBitTick = dirTick[1];

  // B-pin output clock
  always_comb begin
    case (pinSel)
      2'b00:   trxcOut = rtxcIn;
      2'b01:   trxcOut = srcLevel[txSel];
      2'b10:   trxcOut = brgClk;
      default: trxcOut = recovClkIn;
    endcase
  end

endmodule

// File: rtl/sccClockGen.sv
module sccClockGen
  import sccClkPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] clkCtrlReg,
  input  logic [BYTE_W-1:0] pllCtrlReg,
  input  logic [BYTE_W-1:0] modeReg,
  input  logic [BYTE_W-1:0] intCtrlReg,
  input  logic [BYTE_W-1:0] tcLow,
  input  logic [BYTE_W-1:0] tcHigh,
  input  logic              zeroClr,
  input  logic              rtxcIn,
  input  logic              trxcIn,
  input  logic              recovClkIn,
  output logic              txBitTick,
  output logic              rxBitTick,
  output logic              brgClk,
  output logic              brgZero,
  output logic              brgIrq,
  output logic              trxcOut,
  output logic              trxcOe
);

  localparam int TC_W = 2 * BYTE_W;

  brgStrobeS strb;
  logic      cntZero;
  logic      rtxcRise, trxcRise, recovRise;
  logic      unusedRegBits;

  assign unusedRegBits = ^{clkCtrlReg[7], pllCtrlReg[7:2], modeReg[5:0],
                           intCtrlReg[7:2], intCtrlReg[0]};

  assign trxcOe = clkCtrlReg[2];

  sccClkCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .brgEnable  (pllCtrlReg[0]),
    .brgUseSys  (pllCtrlReg[1]),
    .rtxcIn     (rtxcIn),
    .trxcIn     (trxcIn),
    .recovClkIn (recovClkIn),
    .cntZero    (cntZero),
    .rtxcRise   (rtxcRise),
    .trxcRise   (trxcRise),
    .recovRise  (recovRise),
    .strb       (strb)
  );

  sccClkDatapath #(.TC_W(TC_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .tcValue    ({tcHigh, tcLow}),
    .txSel      (clkSrcE'(clkCtrlReg[4:3])),
    .rxSel      (clkSrcE'(clkCtrlReg[6:5])),
    .pinSel     (clkCtrlReg[1:0]),
    .mode       (clkModeE'(modeReg[7:6])),
    .rtxcRise   (rtxcRise),
    .trxcRise   (trxcRise),
    .recovRise  (recovRise),
    .rtxcIn     (rtxcIn),
    .trxcIn     (trxcIn),
    .recovClkIn (recovClkIn),
    .zeroClr    (zeroClr),
    .zeroIntEn  (intCtrlReg[1]),
    .cntZero    (cntZero),
    .brgClk     (brgClk),
    .brgZero    (brgZero),
    .brgIrq     (brgIrq),
    .trxcOut    (trxcOut),
    .txBitTick  (txBitTick),
    .rxBitTick  (rxBitTick)
  );

endmodule

// File: rtl/sccClockGen_chk.sv
module sccClockGen_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] pllCtrlReg,
  input logic [7:0] modeReg,
  input logic [7:0] intCtrlReg,
  input logic       txBitTick,
  input logic       rxBitTick,
  input logic       brgClk,
  input logic       brgZero,
  input logic       brgIrq
);

  // R5: a disabled counter drives its output low at the next edge
  assert_off_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    !pllCtrlReg[0] |=> !brgClk);

  // R9: zero status is only newly set together with an output toggle
  assert_zero_with_toggle_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(brgZero) |-> (brgClk != $past(brgClk)));

  // R9: the interrupt never appears without the status and its enable
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    brgIrq |-> (brgZero && intCtrlReg[1]));

  // R7: the reload tick separates two toggles, so no back-to-back change
  assert_no_double_toggle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (brgClk != $past(brgClk)) |=> $stable(brgClk));

  // R4: with any prescale above one, ticks never come in adjacent cycles
  assert_tx_spacing_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txBitTick && modeReg[7:6] != 2'b00) |=> !txBitTick);

  assert_rx_spacing_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxBitTick && modeReg[7:6] != 2'b00) |=> !rxBitTick);

endmodule

bind sccClockGen sccClockGen_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pllCtrlReg (pllCtrlReg),
  .modeReg    (modeReg),
  .intCtrlReg (intCtrlReg),
  .txBitTick  (txBitTick),
  .rxBitTick  (rxBitTick),
  .brgClk     (brgClk),
  .brgZero    (brgZero),
  .brgIrq     (brgIrq)
);

// File: tb/sccClockGen_test.sv
`timescale 1ns/1ps
module sccClockGen_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] clkCtrlReg = '0, pllCtrlReg = '0, modeReg = '0, intCtrlReg = '0;
  logic [7:0] tcLow = '0, tcHigh = '0;
  logic       zeroClr = 1'b0, rtxcIn = 1'b0, trxcIn = 1'b0, recovClkIn = 1'b0;
  logic       txBitTick, rxBitTick, brgClk, brgZero, brgIrq, trxcOut, trxcOe;

  int errors = 0;
  int checks = 0;
  int cycCount = 0;
  int txTotal = 0, rxTotal = 0, brgRiseTotal = 0;
  logic prevBrg = 1'b0;

  always #2.5 clk = ~clk;

  sccClockGen uut (
    .clk(clk), .rstN(rstN), .clkCtrlReg(clkCtrlReg), .pllCtrlReg(pllCtrlReg),
    .modeReg(modeReg), .intCtrlReg(intCtrlReg), .tcLow(tcLow), .tcHigh(tcHigh),
    .zeroClr(zeroClr), .rtxcIn(rtxcIn), .trxcIn(trxcIn), .recovClkIn(recovClkIn),
    .txBitTick(txBitTick), .rxBitTick(rxBitTick), .brgClk(brgClk),
    .brgZero(brgZero), .brgIrq(brgIrq), .trxcOut(trxcOut), .trxcOe(trxcOe)
  );

  always @(posedge clk) cycCount <= cycCount + 1;

  always @(negedge clk) begin
    if (txBitTick) txTotal = txTotal + 1;
    if (rxBitTick) rxTotal = rxTotal + 1;
    if (brgClk && !prevBrg) brgRiseTotal = brgRiseTotal + 1;
    prevBrg = brgClk;
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    clkCtrlReg = '0; pllCtrlReg = '0; modeReg = '0; intCtrlReg = '0;
    tcLow = '0; tcHigh = '0; zeroClr = 0; rtxcIn = 0; trxcIn = 0; recovClkIn = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulsePin(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (which) 0: rtxcIn = 1; 1: trxcIn = 1; default: recovClkIn = 1; endcase
      @(negedge clk);
      case (which) 0: rtxcIn = 0; 1: trxcIn = 0; default: recovClkIn = 0; endcase
    end
    idle(3);
  endtask

  task automatic waitFlip(output int cyc);
    logic lastV;
    lastV = brgClk;
    do @(negedge clk); while (brgClk == lastV);
    cyc = cycCount;
  endtask

  task automatic testReset();
    doReset();
    idle(4);
    check("R1 txBitTick", int'(txBitTick), 0);
    check("R1 rxBitTick", int'(rxBitTick), 0);
    check("R1 brgClk", int'(brgClk), 0);
    check("R1 brgZero", int'(brgZero), 0);
    check("R1 brgIrq", int'(brgIrq), 0);
  endtask

  task automatic testTxSelect();
    int tx0, rx0, b0;
    doReset();
    clkCtrlReg = 8'b0000_1000;            // tx=B-pin, rx=A-pin
    tx0 = txTotal; rx0 = rxTotal;
    pulsePin(1, 5);
    check("R2 tx from B-pin", txTotal - tx0, 5);
    check("R3 rx ignores B-pin", rxTotal - rx0, 0);
    pulsePin(0, 2);
    check("R2 tx ignores A-pin", txTotal - tx0, 5);
    doReset();
    clkCtrlReg = 8'b0001_1000;            // tx=recovered
    tx0 = txTotal;
    pulsePin(2, 4);
    check("R2 tx from recovered", txTotal - tx0, 4);
    doReset();
    clkCtrlReg = 8'b0001_0000;            // tx=baud counter
    tx0 = txTotal; b0 = brgRiseTotal;
    pllCtrlReg = 8'h03;
    idle(40);
    pllCtrlReg = 8'h00;
    idle(4);
    check("R2 tx from counter matches counter rises", txTotal - tx0, brgRiseTotal - b0);
    check("R2 counter produced rises", int'((brgRiseTotal - b0) >= 8), 1);
  endtask

  task automatic testRxSelect();
    int tx0, rx0;
    doReset();
    clkCtrlReg = 8'b0010_0000;            // rx=B-pin, tx=A-pin
    tx0 = txTotal; rx0 = rxTotal;
    pulsePin(1, 3);
    check("R3 rx from B-pin", rxTotal - rx0, 3);
    check("R3 tx independent", txTotal - tx0, 0);
  endtask

  task automatic testPrescale();
    int tx0;
    doReset();
    clkCtrlReg = 8'b0000_1000; modeReg = 8'h40;
    tx0 = txTotal; pulsePin(1, 48);
    check("R4 x16", txTotal - tx0, 3);
    doReset();
    clkCtrlReg = 8'b0000_1000; modeReg = 8'h80;
    tx0 = txTotal; pulsePin(1, 70);
    check("R4 x32", txTotal - tx0, 2);
    doReset();
    clkCtrlReg = 8'b0000_1000; modeReg = 8'hC0;
    tx0 = txTotal; pulsePin(1, 130);
    check("R4 x64", txTotal - tx0, 2);
  endtask

  task automatic testDisabled();
    int b0;
    doReset();
    pllCtrlReg = 8'h02; tcLow = 8'd1;
    b0 = brgRiseTotal;
    idle(50);
    check("R5 disabled no rise", brgRiseTotal - b0, 0);
    check("R5 disabled no zero", int'(brgZero), 0);
  endtask

  task automatic testPeriod();
    int a, b, c;
    doReset();
    tcLow = 8'd3; pllCtrlReg = 8'h03;
    waitFlip(a); waitFlip(b); waitFlip(c);
    check("R7 half period TC=3 first", b - a, 5);
    check("R7 half period TC=3 second", c - b, 5);
    doReset();
    tcLow = 8'd0; pllCtrlReg = 8'h03;
    waitFlip(a); waitFlip(b);
    check("R7 half period TC=0", b - a, 2);
    doReset();
    tcHigh = 8'd1; tcLow = 8'd0; pllCtrlReg = 8'h03;   // TC=256
    waitFlip(a); waitFlip(b);
    check("R7 half period TC=256", b - a, 258);
  endtask

  task automatic testReloadTiming();
    int a, b, c;
    doReset();
    tcLow = 8'd3; pllCtrlReg = 8'h03;
    waitFlip(a);
    idle(2);
    tcLow = 8'd6;
    waitFlip(b); waitFlip(c);
    check("R8 running half period kept", b - a, 5);
    check("R8 new value after reload", c - b, 8);
  endtask

  task automatic testApinClock();
    int b0, n;
    logic lastV;
    doReset();
    tcLow = 8'd1; pllCtrlReg = 8'h01;      // counter on A-pin edges
    b0 = brgRiseTotal;
    idle(40);
    check("R6 no count without A-pin edges", brgRiseTotal - b0, 0);
    lastV = brgClk;
    n = 0;
    while (brgClk == lastV && n < 20) begin pulsePin(0, 1); n++; end
    lastV = brgClk;
    n = 0;
    while (brgClk == lastV && n < 20) begin pulsePin(0, 1); n++; end
    check("R6 A-pin edges per half period", n, 3);
  endtask

  task automatic testZeroStatus();
    int a;
    doReset();
    tcLow = 8'd0; pllCtrlReg = 8'h03;
    waitFlip(a);
    check("R9 zero set", int'(brgZero), 1);
    check("R9 irq masked", int'(brgIrq), 0);
    intCtrlReg = 8'h02;
    idle(1);
    check("R9 irq enabled", int'(brgIrq), 1);
    pllCtrlReg = 8'h00;
    idle(5);
    check("R9 status held", int'(brgZero), 1);
    zeroClr = 1; idle(1); zeroClr = 0; idle(1);
    check("R9 status cleared", int'(brgZero), 0);
    check("R9 irq cleared", int'(brgIrq), 0);
  endtask

  task automatic testPinOut();
    doReset();
    clkCtrlReg = 8'b0000_0100;            // output, crystal
    idle(1);
    check("R10 oe set", int'(trxcOe), 1);
    rtxcIn = 1; idle(1);
    check("R10 crystal high", int'(trxcOut), 1);
    rtxcIn = 0; idle(1);
    check("R10 crystal low", int'(trxcOut), 0);
    clkCtrlReg = 8'b0001_1101;            // tx=recovered, pin=tx clock
    recovClkIn = 1; idle(1);
    check("R10 tx clock", int'(trxcOut), 1);
    recovClkIn = 0;
    clkCtrlReg = 8'b0000_0111;            // pin=recovered
    recovClkIn = 1; idle(1);
    check("R10 recovered", int'(trxcOut), 1);
    recovClkIn = 0;
    clkCtrlReg = 8'b0000_0110;            // pin=counter
    tcLow = 8'd2; pllCtrlReg = 8'h03;
    idle(3);
    check("R10 pin follows counter", int'(trxcOut), int'(brgClk));
    idle(2);
    check("R10 pin follows counter later", int'(trxcOut), int'(brgClk));
    pllCtrlReg = 8'h00;
    clkCtrlReg = 8'b0000_0000;
    idle(1);
    check("R10 oe clear", int'(trxcOe), 0);
  endtask

  initial begin
    testReset();
    testTxSelect();
    testRxSelect();
    testPrescale();
    testDisabled();
    testPeriod();
    testReloadTiming();
    testApinClock();
    testZeroStatus();
    testPinOut();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycCount > 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycCount);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule